// File: doc/BRIEF.md
# Two-Segment Address Relocation and Protection Unit

The unit sits between the address generator of a processor and its memory port. It maps 18-bit virtual word addresses onto an 18-bit physical word space. In user mode the top address bit selects one of two segments. The low segment holds read-write data and stack, and the high segment holds shareable code that is normally write-protected. Each segment has its own physical base, its own word count and a write-protect flag. In supervisor mode the address goes straight through unchanged and is never checked.

Every request is checked in a single cycle, and the result appears on the registered response outputs one clock later. If the offset falls outside the segment, or a user write targets a protected segment, the access is blocked. The response then carries a cause code, and the faulting virtual address is held for the trap handler. Supervisor software loads the segment registers through a simple write port, and the port does nothing while the processor is in user mode.

Top module: `seg_reloc_unit`

## Requirements
- R1: After reset, rsp_valid, rsp_fault and flt_vaddr are all zero, and both segments have base 0, size 0 and no write protection. Any user access therefore faults on bounds until supervisor software loads the segments.
- R2: A request made with sup_mode high returns rsp_paddr equal to req_vaddr, with rsp_fault low, whatever the segment settings and access type.
- R3: In user mode, req_vaddr[17] = 0 selects segment 0 (low) and req_vaddr[17] = 1 selects segment 1 (high). cfg_seg uses the same numbering.
- R4: A user access that is allowed returns rsp_paddr = (base + req_vaddr[16:0]) mod 2^18, using the selected segment's base.
- R5: A user access whose offset req_vaddr[16:0] is greater than or equal to the segment size returns rsp_fault high, rsp_cause = 1 (bounds) and rsp_paddr = 0. An offset of size-1 is allowed.
- R6: A user write to a segment whose write-protect flag is set returns rsp_fault high, rsp_cause = 2 (write protect) and rsp_paddr = 0. User reads of that segment are allowed. When a request violates both bounds and write protection, the cause is 1. rsp_cause is 0 when there is no fault.
- R7: flt_vaddr takes the virtual address of each faulting request in the same cycle that the fault is reported. It holds that value through non-faulting responses and idle cycles.
- R8: A segment register write (cfg_we high) takes effect only when sup_mode is high in that cycle, and it applies to requests issued from the next cycle onward. In user mode the write is ignored.
- R9: rsp_valid is high exactly one cycle after a cycle with req_valid high. After a cycle without a request, both rsp_valid and rsp_fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A translation request is present this cycle |
| req_vaddr | input | 18 | Virtual word address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| sup_mode | input | 1 | 1 = supervisor (no translation), 0 = user |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_seg | input | 1 | Segment being written: 0 low, 1 high |
| cfg_base | input | 18 | New physical base |
| cfg_size | input | 18 | New segment size in words |
| cfg_wprot | input | 1 | New write-protect flag |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_paddr | output | 18 | Physical word address (0 when blocked) |
| rsp_fault | output | 1 | Access blocked |
| rsp_cause | output | 2 | 0 none, 1 bounds, 2 write protect |
| flt_vaddr | output | 18 | Virtual address of the latest faulting request |

## Verification
The bench probes each segment at its last legal offset and at the first illegal one. A comparator using > instead of >= would let one word past the end through. It also sets a base near the top of the physical space, so a sum that is not truncated to 18 bits, or an offset that keeps the segment-select bit, would give the wrong address. Writes go to a protected segment both inside and outside its bounds, which catches an inverted cause priority, and a supervisor write to that same segment must pass without a fault. A user-mode register write that is wrongly honoured, a write that does not take effect on the very next request, or a fault address that changes on good or idle cycles all show up in the returned addresses and in flt_vaddr.

// File: rtl/seg_reloc_pkg.sv
package seg_reloc_pkg;
  parameter int unsigned VA_W = 18;
  localparam int unsigned OFS_W = VA_W - 1;
  localparam int unsigned NSEG  = 2;
  localparam int unsigned SEL_W = 1;

  typedef struct packed {
    logic [VA_W-1:0] base;
    logic [VA_W-1:0] size;
    logic            wprot;
  } seg_cfg_t;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_BOUNDS = 2'd1,
    CAUSE_WPROT  = 2'd2
  } cause_e;
endpackage

// File: rtl/seg_reloc_regs.sv
// Per-segment relocation/protection registers, written only by supervisor.
module seg_reloc_regs
  import seg_reloc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  seg_cfg_t             wr_cfg,
  output seg_cfg_t [NSEG-1:0]  cfg_q
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic     hit;
    seg_cfg_t cfg_d;

    always_comb begin
      hit   = wr_en && (wr_sel == SEL_W'(g));
      cfg_d = hit ? wr_cfg : cfg_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (hit) begin
        cfg_q[g] <= cfg_d;
      end
    end
  end
endmodule

// File: rtl/seg_reloc_xlate.sv
// Combinational user-mode translation: offset check, protection, relocation.
module seg_reloc_xlate
  import seg_reloc_pkg::*;
(
  input  logic [VA_W-1:0]      vaddr,
  input  logic                 write,
  input  seg_cfg_t [NSEG-1:0]  cfg,
  output logic [VA_W-1:0]      paddr,
  output cause_e               cause
);
  logic [NSEG-1:0][VA_W-1:0] sum_a;
  logic [NSEG-1:0]           oob_a;
  logic [NSEG-1:0]           wpv_a;
  logic [SEL_W-1:0]          sel;
  logic [VA_W-1:0]           ofs;

  assign ofs = VA_W'(vaddr[OFS_W-1:0]);
  assign sel = vaddr[VA_W-1 -: SEL_W];

  for (genvar g = 0; g < NSEG; g++) begin : g_chk
    assign sum_a[g] = cfg[g].base + ofs;
    assign oob_a[g] = (ofs >= cfg[g].size);
    assign wpv_a[g] = write && cfg[g].wprot;
  end

  always_comb begin
    paddr = sum_a[sel];
    cause = CAUSE_NONE;
    if (oob_a[sel]) begin
      cause = CAUSE_BOUNDS;
    end else if (wpv_a[sel]) begin
      cause = CAUSE_WPROT;
    end
  end
endmodule

// File: rtl/seg_reloc_unit.sv
// Two-segment relocation and protection unit, one-cycle registered response.
module seg_reloc_unit
  import seg_reloc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             sup_mode,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_seg,
  input  logic [VA_W-1:0]  cfg_base,
  input  logic [VA_W-1:0]  cfg_size,
  input  logic             cfg_wprot,
  output logic             rsp_valid,
  output logic [VA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  output logic [VA_W-1:0]  flt_vaddr
);
  seg_cfg_t [NSEG-1:0] seg_cfg;
  seg_cfg_t            wr_cfg;
  logic                wr_en;
  logic [VA_W-1:0]     x_paddr;
  cause_e              x_cause;

  logic [VA_W-1:0]     paddr_d, paddr_q;
  cause_e              cause_d, cause_q;
  logic                valid_d, valid_q;
  logic [VA_W-1:0]     flt_d, flt_q;
  logic                flt_en;

  assign wr_en  = cfg_we && sup_mode;
  assign wr_cfg = '{base: cfg_base, size: cfg_size, wprot: cfg_wprot};

  seg_reloc_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (cfg_seg),
    .wr_cfg (wr_cfg),
    .cfg_q  (seg_cfg)
  );

  seg_reloc_xlate u_xlate (
    .vaddr (req_vaddr),
    .write (req_write),
    .cfg   (seg_cfg),
    .paddr (x_paddr),
    .cause (x_cause)
  );

  // next state
  always_comb begin
    valid_d = req_valid;
    cause_d = CAUSE_NONE;
    paddr_d = req_vaddr;
    if (!sup_mode) begin
      cause_d = req_valid ? x_cause : CAUSE_NONE;
      paddr_d = (x_cause == CAUSE_NONE) ? x_paddr : '0;
    end
    flt_en = (cause_d != CAUSE_NONE);
    flt_d  = req_vaddr;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      paddr_q <= '0;
      flt_q   <= '0;
    end else begin
      valid_q <= valid_d;
      cause_q <= cause_d;
      if (req_valid) begin
        paddr_q <= paddr_d;
      end
      if (flt_en) begin
        flt_q <= flt_d;
      end
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_paddr = paddr_q;
  assign rsp_cause = cause_q;
  assign rsp_fault = (cause_q != CAUSE_NONE);
  assign flt_vaddr = flt_q;
endmodule

// File: rtl/seg_reloc_chk.sv
module seg_reloc_chk
  import seg_reloc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            sup_mode,
  input logic            rsp_valid,
  input logic [VA_W-1:0] rsp_paddr,
  input logic            rsp_fault,
  input logic [1:0]      rsp_cause,
  input logic [VA_W-1:0] flt_vaddr
);
  assert_sup_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sup_mode) |=> (rsp_valid && !rsp_fault && rsp_paddr == $past(req_vaddr)));

  assert_fault_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0 && rsp_valid));

  assert_cause_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cause != 2'd3);

  assert_flt_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (flt_vaddr == $past(req_vaddr)));

  assert_flt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> $stable(flt_vaddr));

  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault));
endmodule

bind seg_reloc_unit seg_reloc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_vaddr (req_vaddr),
  .sup_mode  (sup_mode),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_fault (rsp_fault),
  .rsp_cause (rsp_cause),
  .flt_vaddr (flt_vaddr)
);

// File: tb/seg_reloc_unit_test.sv
`timescale 1ns/1ps
module seg_reloc_unit_test;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [17:0] req_vaddr;
  logic        req_write;
  logic        sup_mode;
  logic        cfg_we;
  logic [0:0]  cfg_seg;
  logic [17:0] cfg_base;
  logic [17:0] cfg_size;
  logic        cfg_wprot;
  logic        rsp_valid;
  logic [17:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic [17:0] flt_vaddr;

  seg_reloc_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .sup_mode(sup_mode), .cfg_we(cfg_we), .cfg_seg(cfg_seg),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_wprot(cfg_wprot),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .flt_vaddr(flt_vaddr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic        valid;
    logic [17:0] paddr;
    logic [1:0]  cause;
    logic [17:0] flt;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [17:0] m_base [2];
  logic [17:0] m_size [2];
  logic        m_wp   [2];
  logic [17:0] m_flt;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic rv, input logic [17:0] va, input logic wr, input logic sup,
                       input logic cwe, input logic csel, input logic [17:0] cb,
                       input logic [17:0] cs, input logic cwp, input string tag);
    exp_t        e;
    logic [17:0] ofs;
    @(negedge clk);
    req_valid = rv; req_vaddr = va; req_write = wr; sup_mode = sup;
    cfg_we = cwe; cfg_seg = csel; cfg_base = cb; cfg_size = cs; cfg_wprot = cwp;
    e.valid = rv; e.paddr = '0; e.cause = 2'd0; e.tag = tag;
    if (rv) begin
      if (sup) begin
        e.paddr = va;
      end else begin
        ofs = {1'b0, va[16:0]};
        if (ofs >= m_size[va[17]])             e.cause = 2'd1;
        else if (wr && m_wp[va[17]])           e.cause = 2'd2;
        else                                   e.paddr = m_base[va[17]] + ofs;
        if (e.cause != 2'd0) m_flt = va;
      end
    end
    e.flt = m_flt;
    sb.push_back(e);
    if (cwe && sup) begin
      m_base[csel] = cb; m_size[csel] = cs; m_wp[csel] = cwp;
    end
  endtask

  task automatic req(input logic [17:0] va, input logic wr, input logic sup, input string tag);
    drive(1'b1, va, wr, sup, 1'b0, 1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic cfgw(input logic sel, input logic [17:0] b, input logic [17:0] s,
                      input logic wp, input logic sup, input string tag);
    drive(1'b0, '0, 1'b0, sup, 1'b1, sel, b, s, wp, tag);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, tag);
  endtask

  // monitor: compare one scoreboard item per cycle after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "rsp_valid", 32'(rsp_valid), 32'(e.valid));
        check(e.tag, "rsp_fault", 32'(rsp_fault), 32'(e.cause != 2'd0));
        check(e.tag, "flt_vaddr", 32'(flt_vaddr), 32'(e.flt));
        if (e.valid) begin
          check(e.tag, "rsp_cause", 32'(rsp_cause), 32'(e.cause));
          check(e.tag, "rsp_paddr", 32'(rsp_paddr), 32'(e.paddr));
        end
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_base[i] = '0; m_size[i] = '0; m_wp[i] = 1'b0;
    end
    m_flt = '0;
    rst_n = 1'b0;
    req_valid = 0; req_vaddr = '0; req_write = 0; sup_mode = 0;
    cfg_we = 0; cfg_seg = '0; cfg_base = '0; cfg_size = '0; cfg_wprot = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1", "rsp_fault", 32'(rsp_fault), 32'd0);
    check("R1", "flt_vaddr", 32'(flt_vaddr), 32'd0);
    rst_n = 1'b1;

    req(18'h00005, 1'b0, 1'b0, "R1_size0_bounds");
    req(18'h2ABCD, 1'b1, 1'b1, "R2_sup_pass");
    cfgw(1'b0, 18'h00100, 18'h00040, 1'b0, 1'b0, "R8_user_cfg");
    req(18'h00010, 1'b0, 1'b0, "R8_user_cfg_ignored");
    cfgw(1'b0, 18'h01000, 18'h00400, 1'b0, 1'b1, "R8_cfg_low");
    cfgw(1'b1, 18'h30000, 18'h00800, 1'b1, 1'b1, "R8_cfg_high");
    req(18'h00000, 1'b0, 1'b0, "R4_low_first");
    req(18'h003FF, 1'b0, 1'b0, "R5_low_last");
    req(18'h00400, 1'b0, 1'b0, "R5_low_past");
    req(18'h20000, 1'b0, 1'b0, "R3_high_first");
    idle("R7_hold_idle");
    req(18'h207FF, 1'b0, 1'b0, "R5_high_last");
    req(18'h20800, 1'b0, 1'b0, "R5_high_past");
    req(18'h00010, 1'b1, 1'b0, "R6_low_write_ok");
    req(18'h20004, 1'b1, 1'b0, "R6_high_wprot");
    req(18'h20004, 1'b0, 1'b0, "R6_high_read_ok");
    req(18'h20900, 1'b1, 1'b0, "R6_bounds_priority");
    req(18'h20004, 1'b1, 1'b1, "R2_sup_write_prot");
    idle("R9_idle");
    cfgw(1'b0, 18'h3FF00, 18'h20000, 1'b0, 1'b1, "R4_cfg_wrap");
    req(18'h00200, 1'b0, 1'b0, "R4_wrap");
    req(18'h1FFFF, 1'b1, 1'b0, "R4_max_offset");
    cfgw(1'b1, 18'h30000, 18'h00000, 1'b1, 1'b1, "R8_shrink");
    req(18'h20000, 1'b0, 1'b0, "R8_next_cycle");
    req(18'h00001, 1'b0, 1'b0, "R3_low_still");
    idle("R9_tail");
    idle("R9_tail");
    repeat (3) @(posedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R9 scoreboard: actual %0d left expected 0", sb.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule